// File: doc/BRIEF.md
# Double-Edge PWM Channel with Cascade Synchronization

This block is one channel of a pulse-width modulator. A prescaler divides the channel clock, and a period counter steps from zero up to a programmed terminal value and then wraps. Each output has its own set compare value and clear compare value. With these two values the high interval can sit anywhere in the period, and it can also span the wrap.

All timing settings are written to a shadow set. The shadow set enters the active set only at a period wrap, and only when the transfer-enable input is high. The channel then pulses a transfer-enable output, so a chain of channels can adopt new settings together. A sync input restarts the period. A sync output fires a programmable number of counter ticks after the wrap, so a downstream channel can be phase-shifted from this one.

Capture inputs record the counter value. A single-shot mode halts the channel after one period. A trap input immediately forces every output low and stays latched until it is cleared.

Top module: `dbl_edge_pwm`

## Requirements
- R1: The period counter advances once every `sh_pre`+1 clock cycles while running. The counter holds each value for exactly `sh_pre`+1 cycles.
- R2: The period counter counts 0, 1, … `sh_per` and then returns to 0. One period lasts (`sh_per`+1)·(`sh_pre`+1) cycles.
- R3: Output i takes its set value from `sh_rise[i*CW +: CW]` and its clear value from `sh_fall[i*CW +: CW]`.
  - When set < clear, the output is high while set ≤ count < clear.
  - When set > clear, the output is high while count ≥ set or count < clear.
- R4: When the set value of an output equals its clear value, that output stays low for the whole period.
- R5: While `run` is low:
  - both counters sit at 0;
  - every output is low;
  - the active settings follow the shadow settings on every clock.
- R6: While running, the shadow settings are copied to the active set only on a clock where the counter wraps and `xfer_en_in` is high. `xfer_en_out` is high for one cycle right after each such copy.
- R7: A high `sync_in` clears both counters at the next clock edge without copying settings. Counting resumes from 0 afterwards.
- R8: `sync_out` is high for one cycle, the first cycle in which a tick has brought the counter to the value `sh_dly`. With `sh_dly` = 0, this is the cycle right after the wrap.
- R9: On a rising edge of `cap_in[j]`, field `cap_val[j*CW +: CW]` receives the counter value present at that edge. The other capture fields keep their values.
- R10: With `one_shot` high, the channel halts at the first wrap. After that, the counter stays 0 and the outputs stay low until `run` is dropped.
- R11: `trap_in` forces all outputs low at once, without waiting for a clock edge. The force stays latched after `trap_in` falls, until `trap_clr` is sampled high.
- R12: `match_irq[2i]` pulses for one cycle when a tick brings the counter to output i's set value. `match_irq[2i+1]` does the same for the clear value. Each bit is gated by the matching bit of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Channel enable |
| one_shot | input | 1 | Halt after one period |
| sh_pre | input | CW | Shadow prescale terminal value |
| sh_per | input | CW | Shadow period terminal value |
| sh_rise | input | NOUT*CW | Shadow set compare values, one field per output |
| sh_fall | input | NOUT*CW | Shadow clear compare values, one field per output |
| sh_dly | input | CW | Shadow sync-out delay in ticks |
| irq_en | input | 2*NOUT | Match pulse enables |
| xfer_en_in | input | 1 | Allows commit at wrap |
| xfer_en_out | output | 1 | Commit happened (one-cycle pulse) |
| sync_in | input | 1 | Period restart |
| sync_out | output | 1 | Delayed period marker |
| cap_in | input | NCAP | Capture triggers |
| cap_val | output | NCAP*CW | Captured counter values |
| trap_in | input | 1 | Asynchronous output kill |
| trap_clr | input | 1 | Releases the latched trap |
| pwm_out | output | NOUT | PWM outputs |
| match_irq | output | 2*NOUT | Edge match pulses |
| cnt_out | output | CW | Period counter value |

## Verification
The bench uses the default build: 16-bit counters, two outputs and two capture inputs. With two outputs, every table vector checks a non-wrapping high interval and a wrapping high interval side by side. Equal compare values and clear values beyond the terminal count also appear in the table.

Small prescale and period values keep each period a few tens of cycles at most. This lets the bench measure whole periods by counting samples: the high time, the dwell at zero, and the peak count. It also lets the bench count how many sync, transfer and match pulses land in a single period.

// File: rtl/dbl_edge_pwm.sv
module dbl_edge_pwm #(
  parameter int CW   = 16,
  parameter int NOUT = 2,
  parameter int NCAP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 one_shot,
  input  logic [CW-1:0]        sh_pre,
  input  logic [CW-1:0]        sh_per,
  input  logic [NOUT*CW-1:0]   sh_rise,
  input  logic [NOUT*CW-1:0]   sh_fall,
  input  logic [CW-1:0]        sh_dly,
  input  logic [2*NOUT-1:0]    irq_en,
  input  logic                 xfer_en_in,
  output logic                 xfer_en_out,
  input  logic                 sync_in,
  output logic                 sync_out,
  input  logic [NCAP-1:0]      cap_in,
  output logic [NCAP*CW-1:0]   cap_val,
  input  logic                 trap_in,
  input  logic                 trap_clr,
  output logic [NOUT-1:0]      pwm_out,
  output logic [2*NOUT-1:0]    match_irq,
  output logic [CW-1:0]        cnt_out
);

  logic [CW-1:0]      pre_q, cnt_q, pre_a, per_a, dly_a;
  logic [NOUT*CW-1:0] rise_a, fall_a;
  logic [NCAP-1:0]    cap_q;
  logic               halted, trapped;

  wire          live   = run & ~halted;
  wire          tick   = live & ~sync_in & (pre_q == pre_a);
  wire          wrap   = tick & (cnt_q == per_a);
  wire [CW-1:0] cnt_nx = wrap ? '0 : cnt_q + 1'b1;
  wire          commit = ~run | (wrap & xfer_en_in);

  assign cnt_out = cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!live || sync_in) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == pre_a) begin
      pre_q <= '0;
      cnt_q <= cnt_nx;
    end else begin
      pre_q <= pre_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               halted <= 1'b0;
    else if (!run)            halted <= 1'b0;
    else if (wrap && one_shot) halted <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_a  <= '0;
      per_a  <= '0;
      dly_a  <= '0;
      rise_a <= '0;
      fall_a <= '0;
    end else if (commit) begin
      pre_a  <= sh_pre;
      per_a  <= sh_per;
      dly_a  <= sh_dly;
      rise_a <= sh_rise;
      fall_a <= sh_fall;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xfer_en_out <= 1'b0;
      sync_out    <= 1'b0;
    end else begin
      xfer_en_out <= wrap & xfer_en_in;
      sync_out    <= tick & (cnt_nx == dly_a);
    end

  always_ff @(posedge clk or negedge rst_n or posedge trap_in)
    if (!rst_n)        trapped <= 1'b0;
    else if (trap_in)  trapped <= 1'b1;
    else if (trap_clr) trapped <= 1'b0;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic [CW-1:0] r, f;
    logic          hi;
    assign r  = rise_a[i*CW +: CW];
    assign f  = fall_a[i*CW +: CW];
    assign hi = (r < f) ? (cnt_q >= r && cnt_q < f) :
                (r > f) ? (cnt_q >= r || cnt_q < f) : 1'b0;
    assign pwm_out[i] = hi & live & ~trapped;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) match_irq[2*i +: 2] <= '0;
      else begin
        match_irq[2*i]   <= tick & irq_en[2*i]   & (cnt_nx == r);
        match_irq[2*i+1] <= tick & irq_en[2*i+1] & (cnt_nx == f);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_in;

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      cap_val[j*CW +: CW] <= '0;
      else if (cap_in[j] && !cap_q[j]) cap_val[j*CW +: CW] <= cnt_q;
  end

endmodule

module dbl_edge_pwm_chk #(
  parameter int CW   = 16,
  parameter int NOUT = 2,
  parameter int NCAP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               xfer_en_in,
  input logic               xfer_en_out,
  input logic               sync_out,
  input logic [NCAP-1:0]    cap_in,
  input logic [NCAP*CW-1:0] cap_val,
  input logic [NOUT-1:0]    pwm_out,
  input logic [CW-1:0]      cnt_out,
  input logic [CW-1:0]      per_a,
  input logic [CW-1:0]      dly_a,
  input logic [NOUT*CW-1:0] rise_a,
  input logic [NOUT*CW-1:0] fall_a,
  input logic               halted,
  input logic               trapped
);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_out <= per_a); // R2

  AST_EQUAL_EDGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a[CW-1:0] == fall_a[CW-1:0] |-> !pwm_out[0]); // R4

  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_out == '0); // R5

  AST_XFER_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en_out |-> $past(xfer_en_in)); // R6

  AST_XFER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(xfer_en_in)) |-> $stable(per_a)); // R6

  AST_SYNC_AT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> cnt_out == $past(dly_a)); // R8

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_in[0]) |=> cap_val[CW-1:0] == $past(cnt_out)); // R9

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (cnt_out == '0 && pwm_out == '0)); // R10

  AST_TRAP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    trapped |-> pwm_out == '0); // R11

endmodule

bind dbl_edge_pwm dbl_edge_pwm_chk #(.CW(CW), .NOUT(NOUT), .NCAP(NCAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .xfer_en_in(xfer_en_in),
  .xfer_en_out(xfer_en_out), .sync_out(sync_out), .cap_in(cap_in),
  .cap_val(cap_val), .pwm_out(pwm_out), .cnt_out(cnt_out), .per_a(per_a),
  .dly_a(dly_a), .rise_a(rise_a), .fall_a(fall_a), .halted(halted),
  .trapped(trapped)
);

// File: tb/dbl_edge_pwm_tb.sv
`timescale 1ns/1ps
module dbl_edge_pwm_tb;
  localparam int CW = 16, NOUT = 2, NCAP = 2;

  logic clk = 0, rst_n = 0, run = 0, one_shot = 0;
  logic [CW-1:0] sh_pre = 0, sh_per = 0, sh_dly = 0;
  logic [NOUT*CW-1:0] sh_rise = 0, sh_fall = 0;
  logic [2*NOUT-1:0] irq_en = 0;
  logic xfer_en_in = 1, sync_in = 0, trap_in = 0, trap_clr = 0;
  logic [NCAP-1:0] cap_in = 0;
  logic xfer_en_out, sync_out;
  logic [NCAP*CW-1:0] cap_val;
  logic [NOUT-1:0] pwm_out;
  logic [2*NOUT-1:0] match_irq;
  logic [CW-1:0] cnt_out;

  dbl_edge_pwm #(.CW(CW), .NOUT(NOUT), .NCAP(NCAP)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int hi0, hi1, zeros, maxc, syncs, sync_bad, xfers, irq0, irq1, irq2, irq0_bad;

  // per, pre, rise0, fall0, rise1, fall1, high0, high1 (high in cycles per period)
  localparam int VEC [6][8] = '{
    '{4,  0, 1, 3, 3,  1, 2, 3},
    '{9,  0, 0, 9, 5,  5, 9, 0},
    '{3,  2, 1, 2, 2,  0, 3, 6},
    '{7,  1, 7, 2, 0,  8, 6, 16},
    '{0,  3, 0, 1, 0,  0, 4, 0},
    '{15, 0, 4, 12, 12, 4, 8, 8}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic skip(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic watch(int n);
    hi0 = 0; hi1 = 0; zeros = 0; maxc = 0; syncs = 0; sync_bad = 0;
    xfers = 0; irq0 = 0; irq1 = 0; irq2 = 0; irq0_bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi0 += int'(pwm_out[0]);
      hi1 += int'(pwm_out[1]);
      if (cnt_out == 0) zeros++;
      if (int'(cnt_out) > maxc) maxc = int'(cnt_out);
      if (sync_out) begin
        syncs++;
        if (cnt_out != sh_dly) sync_bad++;
      end
      xfers += int'(xfer_en_out);
      irq0 += int'(match_irq[0]);
      irq1 += int'(match_irq[1]);
      irq2 += int'(match_irq[2]);
      if (match_irq[0] && cnt_out != sh_rise[CW-1:0]) irq0_bad++;
    end
  endtask

  task automatic start(int per, int pre, int r0, int f0, int r1, int f1, int dly, bit os);
    @(negedge clk);
    run = 0;
    sh_per = CW'(per); sh_pre = CW'(pre); sh_dly = CW'(dly); one_shot = os;
    sh_rise = {CW'(r1), CW'(r0)};
    sh_fall = {CW'(f1), CW'(f0)};
    skip(2);
    run = 1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    skip(3);
    rst_n = 1;
    @(negedge clk);
    chk("reset pwm_out", int'(pwm_out), 0);
    chk("reset cnt_out", int'(cnt_out), 0);
    chk("reset sync_out", int'(sync_out), 0);
    chk("reset xfer_en_out", int'(xfer_en_out), 0);
    chk("reset cap_val", int'(cap_val != 0), 0);

    // Table walk: R1, R2, R3, R4 over whole periods
    for (int v = 0; v < 6; v++) begin
      int w;
      w = (VEC[v][0] + 1) * (VEC[v][1] + 1);
      start(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 0, 0);
      skip(3);
      watch(w);
      chk($sformatf("R3 vec%0d out0 high", v), hi0, VEC[v][6]);
      chk($sformatf("R3 R4 vec%0d out1 high", v), hi1, VEC[v][7]);
      chk($sformatf("R1 vec%0d dwell at zero", v), zeros, VEC[v][1] + 1);
      chk($sformatf("R2 vec%0d peak count", v), maxc, VEC[v][0]);
    end

    // R5: stopped
    @(negedge clk); run = 0;
    watch(6);
    chk("R5 stopped outputs", hi0 + hi1, 0);
    chk("R5 stopped count", maxc, 0);

    // R6: shadow held without transfer enable
    start(4, 0, 1, 3, 0, 0, 0, 0);
    skip(4);
    xfer_en_in = 0;
    sh_fall[CW-1:0] = 4;
    skip(12);
    watch(5);
    chk("R6 blocked commit high", hi0, 2);
    chk("R6 no xfer_en_out", xfer_en_in ? 1 : xfers, 0);
    xfer_en_in = 1;
    skip(10);
    watch(5);
    chk("R6 committed high", hi0, 3);
    chk("R6 xfer_en_out pulses", xfers, 1);

    // R7: sync restart
    start(9, 0, 0, 0, 0, 0, 0, 0);
    while (cnt_out != 5) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    sync_in = 0;
    chk("R7 restart to zero", int'(cnt_out), 0);
    @(negedge clk);
    chk("R7 resume", int'(cnt_out), 1);

    // R8: sync_out delay
    start(4, 0, 0, 0, 0, 0, 2, 0);
    skip(3);
    watch(5);
    chk("R8 one pulse per period", syncs, 1);
    chk("R8 pulse at delay", sync_bad, 0);
    start(4, 0, 0, 0, 0, 0, 0, 0);
    skip(3);
    watch(10);
    chk("R8 zero delay pulses", syncs, 2);
    chk("R8 zero delay at wrap", sync_bad, 0);

    // R12: match pulses
    irq_en = 4'b0011;
    start(4, 0, 1, 3, 2, 4, 0, 0);
    skip(3);
    watch(5);
    chk("R12 set match", irq0, 1);
    chk("R12 clear match", irq1, 1);
    chk("R12 disabled match", irq2, 0);
    chk("R12 set match position", irq0_bad, 0);
    irq_en = 0;

    // R9: capture
    start(9, 0, 0, 0, 0, 0, 0, 0);
    while (cnt_out != 3) @(negedge clk);
    cap_in[0] = 1;
    @(negedge clk);
    cap_in[0] = 0;
    chk("R9 captured value", int'(cap_val[CW-1:0]), 3);
    chk("R9 other field untouched", int'(cap_val[2*CW-1:CW]), 0);

    // R10: one-shot
    start(4, 0, 1, 3, 0, 0, 0, 1);
    watch(20);
    chk("R10 single period high", hi0, 2);
    chk("R10 halted at zero", zeros, 16);
    chk("R10 final count", int'(cnt_out), 0);

    // R11: trap
    start(4, 0, 2, 1, 0, 0, 0, 0);
    skip(2);
    while (!pwm_out[0]) @(negedge clk);
    trap_in = 1;
    #1;
    chk("R11 immediate force", int'(pwm_out), 0);
    @(negedge clk);
    trap_in = 0;
    watch(10);
    chk("R11 latched after release", hi0, 0);
    trap_clr = 1;
    @(negedge clk);
    trap_clr = 0;
    watch(5);
    chk("R11 R3 resume after clear", hi0, 4);

    done = 1;
    summary();
  end
endmodule